// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block holds the programmed burst mode of a synchronous DRAM and turns a burst start into the stream of column addresses, one per cycle, that a read or write burst visits. A mode load strobe presents a 12-bit key. The key gives the burst length, the ordering (sequential or interleaved) and the CAS latency. The decoded latency and length are driven out so that data-path and command logic can size their pipelines. A key with any reserved field is refused: the error flag is raised and the previous setting stays in force.

A burst start strobe with a starting column launches a burst. The block then drives the column for each beat, flags the final beat, and stops. A terminate strobe cuts a burst short. A new start on any cycle, including the middle of a running burst, abandons the old burst and begins the new one at once. A full-page burst walks the whole 256-column page and wraps. It has no final beat and runs until it is terminated or replaced. A low clock enable freezes the block for that edge.

Top module: `sbcg_burst_colgen`

## Requirements
- R1: Out of reset the mode is burst length 1, sequential, CAS latency 2, and `mode_err`, `col_valid` and `col_last` are 0. A mode load whose key is valid takes effect on `cas_lat` and `burst_len` in the next cycle. Key bits [6:4] set the latency: 001 gives 1, 010 gives 2, 011 gives 3. Key bit 3 sets the ordering: 0 is sequential, 1 is interleaved. Key bits [2:0] set the length: 000 gives 1, 001 gives 2, 010 gives 4, 011 gives 8, 111 gives the full page of 256. `burst_len` shows the length as a binary count.
- R2: A key is refused if any of these holds: a latency code other than 001/010/011, a length code other than 000/001/010/011/111, length 111 together with bit 3 = 1, or any of bits [11:7] nonzero. A refused key sets `mode_err` in the next cycle and leaves the mode unchanged. A valid load clears `mode_err`.
- R3: In the cycle after an enabled edge with `burst_start` high, `col_valid` is 1 and `col` equals `start_col`. The burst uses the length and ordering that were in force before that edge.
- R4: Sequential beat i (i counted from 0) drives `col` with bits above log2(BL) taken from `start_col` and the low log2(BL) bits equal to (low bits of `start_col` + i) mod BL.
- R5: Interleaved beat i drives `col` with the upper bits of `start_col` and the low log2(BL) bits equal to the low bits of `start_col` XOR i.
- R6: `col_last` is 1 exactly on beat BL-1 of a burst of length 1, 2, 4 or 8. After an enabled edge on that beat with no new start, `col_valid` is 0.
- R7: In a full-page burst, beat i drives `col` = (`start_col` + i) mod 256. `col_last` stays 0 and the burst runs until a terminate or a new start.
- R8: After an enabled edge with `burst_stop` high and `burst_start` low, `col_valid` is 0. When both strobes are high, the start wins.
- R9: A start during a running burst replaces it. The next cycle shows beat 0 of the new burst.
- R10: An edge with `cke` low is ignored. Strobes and key are not acted on, the beat does not advance, and all outputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable; low freezes the block |
| mode_load | input | 1 | Load the mode key |
| mode_key | input | 12 | Mode key: length [2:0], ordering [3], latency [6:4], zero [11:7] |
| burst_start | input | 1 | Start a new burst |
| start_col | input | 8 | Starting column of the new burst |
| burst_stop | input | 1 | Terminate the running burst |
| col | output | 8 | Column of the current beat |
| col_valid | output | 1 | A beat is being driven |
| col_last | output | 1 | Current beat is the final one |
| cas_lat | output | 2 | Decoded CAS latency (1 to 3) |
| burst_len | output | 9 | Decoded burst length (1 to 256) |
| mode_err | output | 1 | Last mode load was refused |

## Verification
On every cycle the assertions check several rules. Beat 0 lands on the requested column. The last beat and a terminate end the burst. A burst in progress keeps running until then. A low enable freezes all outputs. Nonzero upper key bits are refused without any change of mode. The decoded latency and length always stay legal. The exact column order cannot be judged without knowing the burst's length, ordering and starting column, so only the bench's scenarios can show it. This covers sequential wrap inside an aligned block, interleaved XOR order, full-page wrap past column 255, and restarts in mid-burst. The bench checks these cycle by cycle against its own model, under both directed and random strobes.

// File: rtl/sbcg_pkg.sv
package sbcg_pkg;
  localparam int unsigned KEY_W = 12;

  localparam logic [2:0] LEN_1    = 3'b000;
  localparam logic [2:0] LEN_2    = 3'b001;
  localparam logic [2:0] LEN_4    = 3'b010;
  localparam logic [2:0] LEN_8    = 3'b011;
  localparam logic [2:0] LEN_PAGE = 3'b111;

  typedef struct packed {
    logic [2:0] len;
    logic       ilv;
    logic [1:0] cl;
  } mode_t;

  function automatic logic len_ok(input logic [2:0] code, input logic ilv);
    case (code)
      LEN_1, LEN_2, LEN_4, LEN_8: len_ok = 1'b1;
      LEN_PAGE:                   len_ok = !ilv;
      default:                    len_ok = 1'b0;
    endcase
  endfunction

  function automatic logic cl_ok(input logic [2:0] code);
    cl_ok = (code == 3'b001) || (code == 3'b010) || (code == 3'b011);
  endfunction
endpackage

// File: rtl/sbcg_mode_reg.sv
module sbcg_mode_reg
  import sbcg_pkg::*;
#(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             load,
  input  logic [KEY_W-1:0] key,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic [1:0]       cl,
  output logic             err
);
  mode_t cfg_q, cfg_d;
  logic  err_q, err_d;
  logic  key_ok;

  always_comb begin
    key_ok = (key[KEY_W-1:7] == '0) && cl_ok(key[6:4]) && len_ok(key[2:0], key[3]);
    cfg_d  = cfg_q;
    err_d  = err_q;
    if (cke && load) begin
      err_d = !key_ok;
      if (key_ok) begin
        cfg_d.len = key[2:0];
        cfg_d.ilv = key[3];
        cfg_d.cl  = key[5:4];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '{len: LEN_1, ilv: 1'b0, cl: 2'd2};
      err_q <= 1'b0;
    end else begin
      cfg_q <= cfg_d;
      err_q <= err_d;
    end
  end

  assign mask = (cfg_q.len == LEN_PAGE) ? {COL_W{1'b1}} : COL_W'((1 << cfg_q.len) - 1);
  assign ilv  = cfg_q.ilv;
  assign cl   = cfg_q.cl;
  assign err  = err_q;
endmodule

// File: rtl/sbcg_beat_ctr.sv
module sbcg_beat_ctr #(
  parameter int unsigned COL_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             stop,
  input  logic [COL_W-1:0] mask_in,
  input  logic             ilv_in,
  output logic             active,
  output logic [COL_W-1:0] base,
  output logic [COL_W-1:0] beat,
  output logic [COL_W-1:0] mask,
  output logic             ilv,
  output logic             last
);
  logic             act_q, act_d;
  logic [COL_W-1:0] base_q, base_d, beat_q, beat_d, mask_q, mask_d;
  logic             ilv_q, ilv_d;
  logic             full;

  assign full = &mask_q;
  assign last = act_q && !full && (beat_q == mask_q);

  always_comb begin
    act_d  = act_q;
    base_d = base_q;
    beat_d = beat_q;
    mask_d = mask_q;
    ilv_d  = ilv_q;
    if (cke) begin
      if (start) begin
        act_d  = 1'b1;
        base_d = start_col;
        beat_d = '0;
        mask_d = mask_in;
        ilv_d  = ilv_in;
      end else if (stop || last) begin
        act_d  = 1'b0;
      end else if (act_q) begin
        beat_d = beat_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      base_q <= '0;
      beat_q <= '0;
      mask_q <= '0;
      ilv_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      base_q <= base_d;
      beat_q <= beat_d;
      mask_q <= mask_d;
      ilv_q  <= ilv_d;
    end
  end

  assign active = act_q;
  assign base   = base_q;
  assign beat   = beat_q;
  assign mask   = mask_q;
  assign ilv    = ilv_q;
endmodule

// File: rtl/sbcg_addr_map.sv
module sbcg_addr_map #(
  parameter int unsigned COL_W = 8
) (
  input  logic [COL_W-1:0] base,
  input  logic [COL_W-1:0] beat,
  input  logic [COL_W-1:0] mask,
  input  logic             ilv,
  output logic [COL_W-1:0] col
);
  logic [COL_W-1:0] sum;
  assign sum = base + beat;

  for (genvar i = 0; i < COL_W; i++) begin : g_bit
    assign col[i] = !mask[i] ? base[i] : (ilv ? (base[i] ^ beat[i]) : sum[i]);
  end
endmodule

// File: rtl/sbcg_burst_colgen.sv
module sbcg_burst_colgen
  import sbcg_pkg::*;
#(
  parameter int unsigned COL_W = 8,
  localparam int unsigned LEN_W = COL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cke,
  input  logic             mode_load,
  input  logic [KEY_W-1:0] mode_key,
  input  logic             burst_start,
  input  logic [COL_W-1:0] start_col,
  input  logic             burst_stop,
  output logic [COL_W-1:0] col,
  output logic             col_valid,
  output logic             col_last,
  output logic [1:0]       cas_lat,
  output logic [LEN_W-1:0] burst_len,
  output logic             mode_err
);
  logic [COL_W-1:0] cur_mask, b_mask, b_base, b_beat;
  logic             cur_ilv, b_ilv;

  sbcg_mode_reg #(.COL_W(COL_W)) u_mode (
    .clk (clk), .rst_n (rst_n), .cke (cke), .load (mode_load), .key (mode_key),
    .mask (cur_mask), .ilv (cur_ilv), .cl (cas_lat), .err (mode_err)
  );

  sbcg_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk (clk), .rst_n (rst_n), .cke (cke), .start (burst_start),
    .start_col (start_col), .stop (burst_stop), .mask_in (cur_mask),
    .ilv_in (cur_ilv), .active (col_valid), .base (b_base), .beat (b_beat),
    .mask (b_mask), .ilv (b_ilv), .last (col_last)
  );

  sbcg_addr_map #(.COL_W(COL_W)) u_map (
    .base (b_base), .beat (b_beat), .mask (b_mask), .ilv (b_ilv), .col (col)
  );

  assign burst_len = {1'b0, cur_mask} + 1'b1;
endmodule

// File: rtl/sbcg_chk.sv
module sbcg_chk #(
  parameter int unsigned COL_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cke,
  input logic             mode_load,
  input logic [11:0]      mode_key,
  input logic             burst_start,
  input logic [COL_W-1:0] start_col,
  input logic             burst_stop,
  input logic [COL_W-1:0] col,
  input logic             col_valid,
  input logic             col_last,
  input logic [1:0]       cas_lat,
  input logic [COL_W:0]   burst_len,
  input logic             mode_err
);
  p_cl_legal_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cas_lat != 2'd0);
  p_len_pow2_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(burst_len) == 1);
  p_badkey_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cke && mode_load && (mode_key[11:7] != 5'd0)
    |=> mode_err && $stable(cas_lat) && $stable(burst_len));
  p_start_col_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cke && burst_start |=> col_valid && (col == $past(start_col)));
  p_last_valid_r6: assert property (@(posedge clk) disable iff (!rst_n)
    col_last |-> col_valid);
  p_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cke && col_last && !burst_start |=> !col_valid);
  p_stop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cke && burst_stop && !burst_start |=> !col_valid);
  p_cont_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cke && col_valid && !col_last && !burst_stop |=> col_valid);
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |=> $stable(col_valid) && $stable(col) && $stable(col_last)
             && $stable(mode_err) && $stable(burst_len) && $stable(cas_lat));
endmodule

bind sbcg_burst_colgen sbcg_chk #(.COL_W(COL_W)) u_chk (
  .clk (clk), .rst_n (rst_n), .cke (cke), .mode_load (mode_load),
  .mode_key (mode_key), .burst_start (burst_start), .start_col (start_col),
  .burst_stop (burst_stop), .col (col), .col_valid (col_valid),
  .col_last (col_last), .cas_lat (cas_lat), .burst_len (burst_len),
  .mode_err (mode_err)
);

// File: tb/sbcg_burst_colgen_tb.sv
module sbcg_burst_colgen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cke = 1'b1;
  logic        mode_load = 1'b0;
  logic [11:0] mode_key = '0;
  logic        burst_start = 1'b0;
  logic [7:0]  start_col = '0;
  logic        burst_stop = 1'b0;
  logic [7:0]  col;
  logic        col_valid, col_last, mode_err;
  logic [1:0]  cas_lat;
  logic [8:0]  burst_len;

  int total = 0;
  int bad = 0;

  // reference state
  int m_mask = 0, m_cl = 2, m_ilv = 0, m_err = 0;
  int b_act = 0, b_base = 0, b_beat = 0, b_mask = 0, b_ilv = 0;

  always #2 clk = ~clk;

  sbcg_burst_colgen u_dut (
    .clk (clk), .rst_n (rst_n), .cke (cke), .mode_load (mode_load),
    .mode_key (mode_key), .burst_start (burst_start), .start_col (start_col),
    .burst_stop (burst_stop), .col (col), .col_valid (col_valid),
    .col_last (col_last), .cas_lat (cas_lat), .burst_len (burst_len),
    .mode_err (mode_err)
  );

  function automatic int key_good(input logic [11:0] k);
    int lc = k[2:0];
    int cc = k[6:4];
    if (k[11:7] != 0) return 0;
    if (cc < 1 || cc > 3) return 0;
    if (lc == 7) return (k[3] == 1'b0) ? 1 : 0;
    return (lc <= 3) ? 1 : 0;
  endfunction

  function automatic int exp_col(input int base, input int beat, input int mask, input int ilv);
    int low = ilv ? ((base ^ beat) & mask) : ((base + beat) & mask);
    return (base & ~mask & 255) | low;
  endfunction

  function automatic int exp_last();
    return (b_act != 0 && b_mask != 255 && b_beat == b_mask) ? 1 : 0;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compare(input string tag);
    check(tag, "col_valid", int'(col_valid), b_act);
    check(tag, "col_last", int'(col_last), exp_last());
    if (b_act != 0) check(tag, "col", int'(col), exp_col(b_base, b_beat, b_mask, b_ilv));
    check(tag, "mode_err", int'(mode_err), m_err);
    check(tag, "cas_lat", int'(cas_lat), m_cl);
    check(tag, "burst_len", int'(burst_len), m_mask + 1);
  endtask

  task automatic step(input string tag);
    int lc;
    @(posedge clk);
    if (cke) begin
      if (burst_start) begin
        b_act = 1; b_base = int'(start_col); b_beat = 0; b_mask = m_mask; b_ilv = m_ilv;
      end else if (burst_stop || exp_last() != 0) begin
        b_act = 0;
      end else if (b_act != 0) begin
        b_beat = (b_beat + 1) & 255;
      end
      if (mode_load) begin
        if (key_good(mode_key) != 0) begin
          lc = mode_key[2:0];
          m_mask = (lc == 7) ? 255 : ((1 << lc) - 1);
          m_ilv = mode_key[3];
          m_cl = mode_key[5:4];
          m_err = 0;
        end else begin
          m_err = 1;
        end
      end
    end
    @(negedge clk);
    compare(tag);
    mode_load = 1'b0; burst_start = 1'b0; burst_stop = 1'b0; cke = 1'b1;
  endtask

  task automatic load_key(input logic [11:0] k, input string tag);
    mode_load = 1'b1; mode_key = k; step(tag);
  endtask

  task automatic go(input logic [7:0] c, input string tag);
    burst_start = 1'b1; start_col = c; step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd5151));
    repeat (3) @(negedge clk);
    compare("R1");                 // reset state
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R1: latency 3, length 4, sequential
    load_key(12'b0000_0011_0010, "R1");
    // R4/R6: start 0x45 -> 45 46 47 44, last on 4th
    go(8'h45, "R3");
    repeat (4) step("R4");
    step("R6");
    // R5: interleaved, length 8, start 0x35 -> 35 34 37 36 31 30 33 32
    load_key(12'b0000_0010_1011, "R1");
    go(8'h35, "R5");
    repeat (8) step("R5");
    // R7: full page from 0xFE wraps past 255, then stop (R8)
    load_key(12'b0000_0001_0111, "R7");
    go(8'hFE, "R7");
    repeat (300) step("R7");
    burst_stop = 1'b1; step("R8");
    // R8: start wins over stop
    burst_stop = 1'b1; go(8'h10, "R8");
    // R9: restart in mid burst
    step("R9");
    go(8'h80, "R9");
    step("R9");
    // R2: refused keys keep mode
    load_key(12'b0000_1001_0011, "R2");   // bit 7 set
    load_key(12'b0000_0000_0010, "R2");   // latency code 000
    load_key(12'b0000_0001_1111, "R2");   // full page with interleave
    load_key(12'b0000_0001_0100, "R2");   // length code 100
    load_key(12'b0000_0001_0001, "R2");   // valid load clears error
    // R10: cke low freezes a burst and ignores strobes
    go(8'h21, "R10");
    cke = 1'b0; burst_stop = 1'b1; step("R10");
    cke = 1'b0; mode_load = 1'b1; mode_key = 12'h7FF; step("R10");
    cke = 1'b0; burst_start = 1'b1; start_col = 8'h99; step("R10");
    step("R10");
    step("R6");
    // length 1
    load_key(12'b0000_0010_0000, "R1");
    go(8'h77, "R6");
    step("R6");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [11:0] k;
      int lsel;
      cke = ($urandom_range(0, 9) != 0);
      burst_start = ($urandom_range(0, 6) == 0);
      start_col = 8'($urandom_range(0, 255));
      burst_stop = ($urandom_range(0, 19) == 0);
      mode_load = ($urandom_range(0, 11) == 0);
      if ($urandom_range(0, 4) == 0) begin
        k = 12'($urandom_range(0, 4095));
      end else begin
        lsel = $urandom_range(0, 4);
        k = '0;
        k[2:0] = (lsel == 4) ? 3'd7 : 3'(lsel);
        k[3] = (lsel == 4) ? 1'b0 : 1'($urandom_range(0, 1));
        k[6:4] = 3'($urandom_range(1, 3));
      end
      mode_key = k;
      step("R9");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule